// File: doc/BRIEF.md
# Floating-Point Compare Condition-Mask Generator

This block takes two IEEE-754 binary operands, s1 and s2, and turns their ordering into one 32-bit condition word that software can park in a general register. Each relation gets its own bit, so a later conditional branch only has to test a single bit of the word. Besides the six ordinary relations, four bits describe where s1 sits relative to the interval whose ends are zero and s2. An unordered flag and an ordered flag show whether either operand was a NaN.

The operands arrive already formatted, with a valid strobe. The mask appears one clock later together with its own valid strobe. Between results the mask keeps its last value. Internally each operand is mapped onto an ordered integer key, with negative zero folded onto positive zero. One unsigned magnitude compare then yields less, equal or greater for s1 against s2, and a second one gives the same for s1 against zero.

Top module: `fcmp_mask_unit`

## Requirements
- R1: When either operand is a NaN (exponent field all ones and fraction non-zero), the mask is exactly 0x4000_0000: bit 30 is set and every other bit is 0.
- R2: When neither operand is a NaN, bit 31 is set and bit 30 is clear.
- R3: For ordered operands, bit 20 is s1 == s2 and bit 21 is s1 != s2.
- R4: For ordered operands, bit 22 is s1 > s2 and bit 23 is s1 <= s2.
- R5: For ordered operands, bit 24 is s1 < s2 and bit 25 is s1 >= s2.
- R6: For ordered operands, bit 26 is set when s1 < 0 or s1 > s2.
- R7: For ordered operands, bit 27 is set when s1 > 0 and s1 < s2, and bit 28 is set when s1 >= 0 and s1 <= s2.
- R8: For ordered operands, bit 29 is set when s1 <= 0 or s1 >= s2.
- R9: Negative zero and positive zero compare equal, and infinities and subnormals order as ordinary values.
- R10: Bits 0 to 19 of the mask are always 0.
- R11: out_valid rises on the clock edge after an edge that samples in_valid high, and stays low otherwise. out_mask changes only on such an edge and holds its value while in_valid is low, whatever the operand inputs carry.
- R12: While rst_n is low, out_valid and out_mask are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands on in_s1/in_s2 are to be compared |
| in_s1 | input | 1+EXP_W+MAN_W (64) | First operand s1 |
| in_s2 | input | 1+EXP_W+MAN_W (64) | Second operand s2 |
| out_valid | output | 1 | out_mask carries a new result this cycle |
| out_mask | output | 32 | Condition word |

## Verification
The bench builds the block with its default parameters, EXP_W = 11 and MAN_W = 52. That is the double format, so the bench's reference model can convert each operand to a native real and take every relation from the simulator's own floating-point compare. This lets the run reach both zeros, subnormals, the largest finite value, both infinities, and quiet and signalling NaNs in either slot. Operands are drawn from a pool of these special encodings mixed with random bit patterns, so equal pairs and sign crossings around zero occur often. Idle cycles with changing operands probe the hold behaviour.

// File: rtl/fcmp_mask_pkg.sv
package fcmp_mask_pkg;

  localparam int COND_W = 32;

  // Bit positions of the condition word; branch logic decodes these.
  localparam int B_ORD    = 31;
  localparam int B_UNORD  = 30;
  localparam int B_OUT_LO = 29;   // s1 <= 0 or s1 >= s2
  localparam int B_IN_CL  = 28;   // 0 <= s1 <= s2
  localparam int B_IN_OP  = 27;   // 0 <  s1 <  s2
  localparam int B_OUT_CL = 26;   // s1 <  0 or s1 >  s2
  localparam int B_GE     = 25;
  localparam int B_LT     = 24;
  localparam int B_LE     = 23;
  localparam int B_GT     = 22;
  localparam int B_NE     = 21;
  localparam int B_EQ     = 20;
  localparam int B_LOW_TOP = 19;  // bits 19..0 stay zero

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } rel_t;

endpackage

// File: rtl/fcmp_operand_class.sv
module fcmp_operand_class #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] op,
  output logic                 is_nan,
  output logic                 is_zero
);

  localparam int W = 1 + EXP_W + MAN_W;

  function automatic logic nan_of(input logic [W-1:0] v);
    return (&v[W-2:MAN_W]) && (|v[MAN_W-1:0]);
  endfunction

  function automatic logic zero_of(input logic [W-1:0] v);
    return ~|v[W-2:0];
  endfunction

  assign is_nan  = nan_of(op);
  assign is_zero = zero_of(op);

endmodule

// File: rtl/fcmp_order_cmp.sv
module fcmp_order_cmp
  import fcmp_mask_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic         a_zero,
  input  logic [W-1:0] b,
  input  logic         b_zero,
  output rel_t         rel
);

  // Sign-magnitude to monotone unsigned key; both zeros share one key.
  function automatic logic [W-1:0] order_key(input logic [W-1:0] v,
                                             input logic        zero);
    logic [W-1:0] t;
    t = zero ? '0 : v;
    if (t[W-1]) return ~t;
    return {1'b1, t[W-2:0]};
  endfunction

  logic [W-1:0] key_a, key_b;

  assign key_a = order_key(a, a_zero);
  assign key_b = order_key(b, b_zero);

  always_comb begin
    rel.lt = key_a <  key_b;
    rel.eq = key_a == key_b;
    rel.gt = key_a >  key_b;
  end

endmodule

// File: rtl/fcmp_mask_pack.sv
module fcmp_mask_pack
  import fcmp_mask_pkg::*;
(
  input  logic              unordered,
  input  rel_t              rel_s2,
  input  rel_t              rel_zero,
  output logic [COND_W-1:0] mask
);

  function automatic logic [COND_W-1:0] build(input logic un,
                                              input rel_t r,
                                              input rel_t z);
    logic [COND_W-1:0] m;
    m = '0;
    if (un) begin
      m[B_UNORD] = 1'b1;
    end else begin
      m[B_ORD]    = 1'b1;
      m[B_EQ]     = r.eq;
      m[B_NE]     = ~r.eq;
      m[B_GT]     = r.gt;
      m[B_LE]     = ~r.gt;
      m[B_LT]     = r.lt;
      m[B_GE]     = ~r.lt;
      m[B_OUT_CL] = z.lt | r.gt;
      m[B_IN_OP]  = z.gt & r.lt;
      m[B_IN_CL]  = ~z.lt & ~r.gt;
      m[B_OUT_LO] = ~z.gt | ~r.lt;
    end
    return m;
  endfunction

  assign mask = build(unordered, rel_s2, rel_zero);

endmodule

// File: rtl/fcmp_mask_unit.sv
module fcmp_mask_unit
  import fcmp_mask_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [EXP_W+MAN_W:0]    in_s1,
  input  logic [EXP_W+MAN_W:0]    in_s2,
  output logic                    out_valid,
  output logic [COND_W-1:0]       out_mask
);

  localparam int W = 1 + EXP_W + MAN_W;
  localparam int N_OPS = 2;

  logic [W-1:0] ops      [N_OPS];
  logic         op_nan   [N_OPS];
  logic         op_zero  [N_OPS];
  rel_t         rel      [N_OPS];   // [0]: s1 vs s2, [1]: s1 vs zero

  assign ops[0] = in_s1;
  assign ops[1] = in_s2;

  genvar g;
  generate
    for (g = 0; g < N_OPS; g++) begin : g_class
      fcmp_operand_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
        .op      (ops[g]),
        .is_nan  (op_nan[g]),
        .is_zero (op_zero[g])
      );
    end
    for (g = 0; g < N_OPS; g++) begin : g_cmp
      fcmp_order_cmp #(.W(W)) u_cmp (
        .a      (in_s1),
        .a_zero (op_zero[0]),
        .b      ((g == 0) ? in_s2 : {W{1'b0}}),
        .b_zero ((g == 0) ? op_zero[1] : 1'b1),
        .rel    (rel[g])
      );
    end
  endgenerate

  // Named internal events for the checks below.
  logic              nan_any;
  rel_t              rel_main;
  rel_t              rel_zero;
  logic              both_zero;
  logic [COND_W-1:0] mask_next;

  assign nan_any   = op_nan[0] | op_nan[1];
  assign rel_main  = rel[0];
  assign rel_zero  = rel[1];
  assign both_zero = op_zero[0] & op_zero[1];

  fcmp_mask_pack u_pack (
    .unordered (nan_any),
    .rel_s2    (rel_main),
    .rel_zero  (rel_zero),
    .mask      (mask_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_mask <= mask_next;
    end
  end

  // R1
  nan_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_any) |=> (out_mask == (32'h1 << B_UNORD)));

  // R2
  ord_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask[B_ORD] ^ out_mask[B_UNORD]));

  // R3
  eq_ne_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mask[B_ORD]) |-> (out_mask[B_EQ] ^ out_mask[B_NE]));

  // R5
  one_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mask[B_ORD]) |->
      ($countones({out_mask[B_LT], out_mask[B_EQ], out_mask[B_GT]}) == 1));

  // R9
  zero_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && both_zero) |-> rel_main.eq);

  // R10
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_mask[B_LOW_TOP:0] == '0);

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_mask));

endmodule

// File: tb/tb_fcmp_mask_unit.sv
module tb_fcmp_mask_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_s1 = '0;
  logic [63:0] in_s2 = '0;
  logic        out_valid;
  logic [31:0] out_mask;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state, updated once per clock edge
  logic        mdl_valid = 1'b0;
  logic [31:0] mdl_mask  = '0;

  always #4 clk = ~clk;   // 125 MHz

  fcmp_mask_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_s1     (in_s1),
    .in_s2     (in_s2),
    .out_valid (out_valid),
    .out_mask  (out_mask)
  );

  function automatic bit is_nan64(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic logic [31:0] ref_mask(input logic [63:0] a,
                                           input logic [63:0] b);
    real x, y;
    logic [31:0] m;
    m = 32'h0;
    if (is_nan64(a) || is_nan64(b)) begin
      m[30] = 1'b1;                               // R1
      return m;
    end
    x = $bitstoreal(a);
    y = $bitstoreal(b);
    m[31] = 1'b1;                                 // R2
    m[20] = (x == y);  m[21] = (x != y);          // R3
    m[22] = (x >  y);  m[23] = (x <= y);          // R4
    m[24] = (x <  y);  m[25] = (x >= y);          // R5
    m[26] = (x < 0.0) || (x > y);                 // R6
    m[27] = (x > 0.0) && (x < y);                 // R7
    m[28] = (x >= 0.0) && (x <= y);               // R7
    m[29] = (x <= 0.0) || (x >= y);               // R8
    return m;
  endfunction

  function automatic string req_of(input logic [31:0] diff);
    if (diff[30])                return "R1";
    if (diff[31])                return "R2";
    if (diff[21:20] != 0)        return "R3";
    if (diff[23:22] != 0)        return "R4";
    if (diff[25:24] != 0)        return "R5";
    if (diff[26])                return "R6";
    if (diff[28:27] != 0)        return "R7";
    if (diff[29])                return "R8";
    return "R10";
  endfunction

  function automatic logic [63:0] pick_op();
    case ($urandom % 16)
      0:  return 64'h0000_0000_0000_0000;  // +0
      1:  return 64'h8000_0000_0000_0000;  // -0
      2:  return 64'h3FF0_0000_0000_0000;  // 1.0
      3:  return 64'hBFF0_0000_0000_0000;  // -1.0
      4:  return 64'h4000_0000_0000_0000;  // 2.0
      5:  return 64'h3FE0_0000_0000_0000;  // 0.5
      6:  return 64'h7FF0_0000_0000_0000;  // +inf
      7:  return 64'hFFF0_0000_0000_0000;  // -inf
      8:  return 64'h7FF8_0000_0000_0000;  // quiet NaN
      9:  return 64'hFFF0_0000_0000_0001;  // signalling NaN, negative
      10: return 64'h0000_0000_0000_0001;  // smallest subnormal
      11: return 64'h8000_0000_0000_0001;
      12: return 64'h7FEF_FFFF_FFFF_FFFF;  // largest finite
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic check(input string tag_ctx);
    n_cmp++;
    if (out_valid !== mdl_valid) begin
      n_bad++;
      $display("FAIL R11 %s out_valid actual=%0b expected=%0b",
               tag_ctx, out_valid, mdl_valid);
    end
    if (out_mask !== mdl_mask) begin
      n_bad++;
      $display("FAIL %s %s out_mask actual=%08h expected=%08h",
               req_of(out_mask ^ mdl_mask), tag_ctx, out_mask, mdl_mask);
    end
  endtask

  // Drive at negedge, model the edge, compare at the next negedge.
  task automatic step(input bit v, input logic [63:0] a, input logic [63:0] b,
                      input string tag_ctx);
    in_valid = v;
    in_s1    = a;
    in_s2    = b;
    @(posedge clk);
    if (!rst_n) begin
      mdl_valid = 1'b0;
      mdl_mask  = '0;
    end else begin
      mdl_valid = v;
      if (v) mdl_mask = ref_mask(a, b);
    end
    @(negedge clk);
    check(tag_ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R12: reset state while inputs are active
    for (int i = 0; i < 3; i++)
      step(1'b1, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, "R12 reset");
    rst_n = 1'b1;

    // R3 R4 R5: plain relations
    step(1'b1, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R3 equal");
    step(1'b1, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R4 greater");
    step(1'b1, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, "R5 less");
    step(1'b1, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, "R4 negatives");
    // R6 R7 R8: range tests
    step(1'b1, 64'h3FE0_0000_0000_0000, 64'h4000_0000_0000_0000, "R7 inside");
    step(1'b1, 64'hBFE0_0000_0000_0000, 64'h4000_0000_0000_0000, "R6 below zero");
    step(1'b1, 64'h0000_0000_0000_0000, 64'h4000_0000_0000_0000, "R8 at zero");
    step(1'b1, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, "R7 at s2");
    step(1'b1, 64'h3FE0_0000_0000_0000, 64'hBFF0_0000_0000_0000, "R6 s2 negative");
    // R9: signed zeros, infinities, subnormals
    step(1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, "R9 -0 vs +0");
    step(1'b1, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, "R9 +0 vs -0");
    step(1'b1, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R9 -0 vs 1");
    step(1'b1, 64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, "R9 infinities");
    step(1'b1, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, "R9 subnormal");
    // R1: NaN in either slot
    step(1'b1, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R1 nan s1");
    step(1'b1, 64'h3FF0_0000_0000_0000, 64'hFFF0_0000_0000_0001, "R1 nan s2");
    step(1'b1, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0000, "R1 both nan");
    // R11: idle cycles with changing operands must not disturb the mask
    step(1'b0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R11 idle");
    step(1'b0, 64'hBFF0_0000_0000_0000, 64'h4000_0000_0000_0000, "R11 idle");
    step(1'b1, 64'h4000_0000_0000_0000, 64'h3FE0_0000_0000_0000, "R11 resume");
    step(1'b0, 64'h7FF8_0000_0000_0000, 64'h0000_0000_0000_0000, "R11 idle nan");

    // Mixed pool of specials and random patterns; R10 checked on every compare
    for (int i = 0; i < 4000; i++)
      step(($urandom % 5) != 0, pick_op(), pick_op(), "R10 mixed");

    // R12: reset in mid-stream clears the outputs
    rst_n = 1'b0;
    step(1'b1, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R12 reassert");
    rst_n = 1'b1;
    step(1'b0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R12 after");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule